// File: doc/BRIEF.md
# Coherent Neighbor Cache Controller

This block holds a small, fully associative set of recently computed point neighborhoods. Each entry keeps the query position that produced it, a scalar tolerance and the list of neighbor pointers. A new query is served from an entry when it lies close enough to that entry's query position, so a spatially coherent stream of queries can often skip a full tree search. Hits are decided by a geometric tolerance test, not by an exact tag match.

A request is accepted when `req_ready_o` is high. The controller then tests the entries one per cycle with a single distance checker. It always visits every entry and keeps the most recently used one that passes. It then produces either a hit, carrying the stored neighbor list, or a miss, carrying the search request to issue. A completed search is written back through the fill port into the least recently used entry. The controller computes that entry's tolerance there, in one of two modes.

In nearest-neighbor mode the search gathers K+1 neighbors. The tolerance is half the gap between the (K+1)-th and K-th distances, and the (K+1)-th neighbor is never delivered. In radius mode the tolerance is the distance of the farthest slot. A query radius shrinks the usable tolerance, and missed searches are issued with an enlarged radius. Distances are fixed-point. The test compares the squared displacement with the squared tolerance.

Top module: `cnc_ctrl`

## Requirements
- R1: After reset `req_ready_o` is high, `hit_o` and `miss_o` are low, and every entry is empty, so the first request after reset misses.
- R2: Each accepted request produces exactly one one-cycle pulse on either `hit_o` or `miss_o`, N_ENTRY clock edges after the accepting edge. `req_ready_o` is low from the accepting edge until the response cycle has passed.
- R3: In nearest-neighbor mode (`radius_mode_i`=0) an entry's tolerance is c = floor((d_hi - d_lo)/2), with d_lo the K-th and d_hi the (K+1)-th distance of its fill. A query hits when dx²+dy²+dz² < c², strictly. A hit returns the entry's physical index, its K stored pointers (slot 0 in the low PTR_W bits) and a count of K.
- R4: In nearest-neighbor mode a miss returns the query position on `miss_pos_o` and an all-ones (unbounded) radius on `miss_rad_o`.
- R5: In radius mode (`radius_mode_i`=1) the tolerance is d_hi. A query with radius r hits only when c > r and the squared displacement is below (c - r)²; a zero or negative margin is a miss. A miss requests radius r + floor(r / 2^ALPHA_SH), saturated at all ones.
- R6: In radius mode a fill slot s (0..K-1) whose bit s in `fill_empty_i` is set is discarded. Its pointer field is delivered as zero and it is not counted, so the delivered count equals the number of clear bits. In nearest-neighbor mode the flags are ignored.
- R7: A fill overwrites the least recently used entry and makes it most recently used, and a hit makes its entry most recently used. Reset ranks entry i at recency i, so fills after reset go to entries N_ENTRY-1, N_ENTRY-2, and so on.
- R8: When several entries pass the test, the response reports the most recently used of them.
- R9: A fill removes the victim from lookup at the edge that accepts it. A request accepted at that same edge never hits the victim's former contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| radius_mode_i | input | 1 | 0: nearest-neighbor mode, 1: radius mode |
| req_valid_i | input | 1 | Query request valid |
| req_ready_o | output | 1 | Controller idle, request accepted this edge if valid |
| req_pos_i | input | 3*COORD_W | Query position, signed x in low bits, then y, z on top |
| req_rad_i | input | DIST_W | Query radius (radius mode) |
| hit_o | output | 1 | One-cycle hit response |
| hit_idx_o | output | IDX_W | Physical index of the hit entry |
| hit_nbr_o | output | K_NBR*PTR_W | Delivered neighbor pointers, slot 0 in low bits |
| hit_cnt_o | output | CNT_W | Number of delivered neighbors |
| miss_o | output | 1 | One-cycle miss response, a search must be issued |
| miss_pos_o | output | 3*COORD_W | Position for the search |
| miss_rad_o | output | DIST_W | Radius for the search |
| fill_valid_i | input | 1 | Completed search result valid |
| fill_pos_i | input | 3*COORD_W | Query position that produced the result |
| fill_dk_i | input | DIST_W | Distance of the K-th neighbor |
| fill_dk1_i | input | DIST_W | Distance of the (K+1)-th, farthest slot |
| fill_ptr_i | input | K_NBR*PTR_W | Pointers of slots 0..K-1, nearest first |
| fill_empty_i | input | K_NBR | Placeholder flag per slot 0..K-1 |

## Verification
The assertions assume that `radius_mode_i` changes only while the cache is empty, between a reset and the first fill. They also assume that a request is held until accepted and that fill results list the K-th distance no farther than the (K+1)-th. The stimulus switches mode only across a reset and drives each request from one negative edge until it is taken. It builds every fill from ordered distances with placeholder slots trailing. Concurrent fill and request traffic is exercised once, deliberately, to cover the refill window. Elsewhere a new operation starts only after the previous response.

// File: rtl/cnc_pkg.sv
`timescale 1ns/1ps
package cnc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_RESP = 2'd2
    } cnc_state_e;
endpackage

// File: rtl/cnc_coh_test.sv
`timescale 1ns/1ps
module cnc_coh_test #(
    parameter int COORD_W = 10,
    parameter int DIST_W  = 12
) (
    input  logic                 radius_mode_i,
    input  logic                 entry_vld_i,
    input  logic [3*COORD_W-1:0] q_new_i,
    input  logic [3*COORD_W-1:0] q_old_i,
    input  logic [DIST_W-1:0]    thr_i,
    input  logic [DIST_W-1:0]    rad_i,
    output logic                 hit_o
);
    localparam int SQ_W  = 2 * (COORD_W + 1);
    localparam int SUM_W = SQ_W + 2;
    localparam int TH_W  = 2 * DIST_W;
    localparam int CMP_W = (SUM_W > TH_W) ? SUM_W : TH_W;

    logic [2:0][SQ_W-1:0] sq_arr;

    for (genvar ax = 0; ax < 3; ax++) begin : g_axis
        logic signed [COORD_W:0]   dx;
        logic signed [SQ_W-1:0]    sq;
        assign dx = $signed(q_new_i[ax*COORD_W +: COORD_W]) - $signed(q_old_i[ax*COORD_W +: COORD_W]);
        assign sq = dx * dx;
        assign sq_arr[ax] = $unsigned(sq);
    end

    logic [SUM_W-1:0]  sum_sq;
    logic [DIST_W:0]   margin;
    logic [TH_W-1:0]   margin_sq;
    logic              margin_pos;

    always_comb begin
        sum_sq = SUM_W'(sq_arr[0]) + SUM_W'(sq_arr[1]) + SUM_W'(sq_arr[2]);
        margin = radius_mode_i ? ({1'b0, thr_i} - {1'b0, rad_i}) : {1'b0, thr_i};
        margin_pos = !margin[DIST_W] && (margin != '0);
        margin_sq = TH_W'(margin[DIST_W-1:0]) * TH_W'(margin[DIST_W-1:0]);
        hit_o = entry_vld_i && margin_pos && (CMP_W'(sum_sq) < CMP_W'(margin_sq));
    end
endmodule

// File: rtl/cnc_fill_calc.sv
`timescale 1ns/1ps
module cnc_fill_calc #(
    parameter int K_NBR  = 4,
    parameter int DIST_W = 12,
    parameter int PTR_W  = 8,
    localparam int CNT_W = $clog2(K_NBR + 1)
) (
    input  logic                     radius_mode_i,
    input  logic [DIST_W-1:0]        dk_i,
    input  logic [DIST_W-1:0]        dk1_i,
    input  logic [K_NBR*PTR_W-1:0]   ptr_i,
    input  logic [K_NBR-1:0]         empty_i,
    output logic [DIST_W-1:0]        thr_o,
    output logic [K_NBR*PTR_W-1:0]   nbr_o,
    output logic [CNT_W-1:0]         cnt_o
);
    for (genvar s = 0; s < K_NBR; s++) begin : g_slot
        assign nbr_o[s*PTR_W +: PTR_W] = (radius_mode_i && empty_i[s]) ? '0 : ptr_i[s*PTR_W +: PTR_W];
    end

    logic [DIST_W-1:0] gap;

    always_comb begin
        gap = (dk1_i >= dk_i) ? (dk1_i - dk_i) : '0;
        thr_o = radius_mode_i ? dk1_i : (gap >> 1);
        cnt_o = CNT_W'(K_NBR);
        if (radius_mode_i) begin
            cnt_o = '0;
            for (int s = 0; s < K_NBR; s++) begin
                if (!empty_i[s]) cnt_o = cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cnc_ctrl.sv
`timescale 1ns/1ps
module cnc_ctrl
    import cnc_pkg::*;
#(
    parameter int N_ENTRY  = 8,
    parameter int K_NBR    = 4,
    parameter int COORD_W  = 10,
    parameter int DIST_W   = 12,
    parameter int PTR_W    = 8,
    parameter int ALPHA_SH = 1,
    localparam int IDX_W   = $clog2(N_ENTRY),
    localparam int CNT_W   = $clog2(K_NBR + 1),
    localparam int POS_W   = 3 * COORD_W,
    localparam int NBR_W   = K_NBR * PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              radius_mode_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [POS_W-1:0]  req_pos_i,
    input  logic [DIST_W-1:0] req_rad_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  hit_idx_o,
    output logic [NBR_W-1:0]  hit_nbr_o,
    output logic [CNT_W-1:0]  hit_cnt_o,
    output logic              miss_o,
    output logic [POS_W-1:0]  miss_pos_o,
    output logic [DIST_W-1:0] miss_rad_o,
    input  logic              fill_valid_i,
    input  logic [POS_W-1:0]  fill_pos_i,
    input  logic [DIST_W-1:0] fill_dk_i,
    input  logic [DIST_W-1:0] fill_dk1_i,
    input  logic [NBR_W-1:0]  fill_ptr_i,
    input  logic [K_NBR-1:0]  fill_empty_i
);
    typedef logic [N_ENTRY-1:0][IDX_W-1:0] rank_t;

    typedef struct packed {
        cnc_state_e                      st;
        logic [IDX_W-1:0]                scan;
        logic                            found;
        logic [IDX_W-1:0]                best;
        logic [POS_W-1:0]                qpos;
        logic [DIST_W-1:0]               qrad;
        logic [N_ENTRY-1:0]              vld;
        rank_t                           rank;
        logic [N_ENTRY-1:0][POS_W-1:0]   epos;
        logic [N_ENTRY-1:0][DIST_W-1:0]  ethr;
        logic [N_ENTRY-1:0][NBR_W-1:0]   enbr;
        logic [N_ENTRY-1:0][CNT_W-1:0]   ecnt;
        logic                            wr_pend;
        logic [IDX_W-1:0]                wr_idx;
        logic [POS_W-1:0]                wr_pos;
        logic [DIST_W-1:0]               wr_thr;
        logic [NBR_W-1:0]                wr_nbr;
        logic [CNT_W-1:0]                wr_cnt;
    } cnc_reg_t;

    // Move entry e to the most recent rank; younger entries age by one.
    function automatic rank_t touch(rank_t r, logic [IDX_W-1:0] e);
        rank_t o;
        o = r;
        for (int f = 0; f < N_ENTRY; f++) begin
            if (r[f] < r[e]) o[f] = r[f] + 1'b1;
        end
        o[e] = '0;
        return o;
    endfunction

    cnc_reg_t          r_q, r_d;
    logic              chk_hit;
    logic [DIST_W-1:0] fc_thr;
    logic [NBR_W-1:0]  fc_nbr;
    logic [CNT_W-1:0]  fc_cnt;
    logic [IDX_W-1:0]  victim;
    logic [DIST_W:0]   grow;

    cnc_fill_calc #(.K_NBR(K_NBR), .DIST_W(DIST_W), .PTR_W(PTR_W)) u_fill (
        .radius_mode_i (radius_mode_i),
        .dk_i          (fill_dk_i),
        .dk1_i         (fill_dk1_i),
        .ptr_i         (fill_ptr_i),
        .empty_i       (fill_empty_i),
        .thr_o         (fc_thr),
        .nbr_o         (fc_nbr),
        .cnt_o         (fc_cnt)
    );

    cnc_coh_test #(.COORD_W(COORD_W), .DIST_W(DIST_W)) u_coh (
        .radius_mode_i (radius_mode_i),
        .entry_vld_i   (r_q.vld[r_q.scan]),
        .q_new_i       (r_q.qpos),
        .q_old_i       (r_q.epos[r_q.scan]),
        .thr_i         (r_q.ethr[r_q.scan]),
        .rad_i         (r_q.qrad),
        .hit_o         (chk_hit)
    );

    always_comb begin
        r_d = r_q;
        victim = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.st    = ST_SCAN;
                    r_d.scan  = '0;
                    r_d.found = 1'b0;
                    r_d.qpos  = req_pos_i;
                    r_d.qrad  = req_rad_i;
                end
            end
            ST_SCAN: begin
                if (chk_hit && (!r_q.found || (r_q.rank[r_q.scan] < r_q.rank[r_q.best]))) begin
                    r_d.found = 1'b1;
                    r_d.best  = r_q.scan;
                end
                if (r_q.scan == IDX_W'(N_ENTRY - 1)) r_d.st = ST_RESP;
                else r_d.scan = r_q.scan + 1'b1;
            end
            ST_RESP: begin
                r_d.st = ST_IDLE;
                if (r_q.found) r_d.rank = touch(r_q.rank, r_q.best);
            end
            default: r_d.st = ST_IDLE;
        endcase

        // Second fill stage: commit the prepared entry.
        if (r_q.wr_pend) begin
            r_d.epos[r_q.wr_idx] = r_q.wr_pos;
            r_d.ethr[r_q.wr_idx] = r_q.wr_thr;
            r_d.enbr[r_q.wr_idx] = r_q.wr_nbr;
            r_d.ecnt[r_q.wr_idx] = r_q.wr_cnt;
            r_d.vld[r_q.wr_idx]  = 1'b1;
            r_d.wr_pend          = 1'b0;
        end

        // First fill stage: claim the oldest entry and hide it from lookup.
        if (fill_valid_i) begin
            for (int e = 0; e < N_ENTRY; e++) begin
                if (r_d.rank[e] == IDX_W'(N_ENTRY - 1)) victim = IDX_W'(e);
            end
            r_d.vld[victim] = 1'b0;
            r_d.rank        = touch(r_d.rank, victim);
            r_d.wr_pend     = 1'b1;
            r_d.wr_idx      = victim;
            r_d.wr_pos      = fill_pos_i;
            r_d.wr_thr      = fc_thr;
            r_d.wr_nbr      = fc_nbr;
            r_d.wr_cnt      = fc_cnt;
            if (r_d.found && (r_d.best == victim)) r_d.found = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int e = 0; e < N_ENTRY; e++) r_q.rank[e] <= IDX_W'(e);
        end else begin
            r_q <= r_d;
        end
    end

    assign grow        = {1'b0, r_q.qrad} + (DIST_W + 1)'(r_q.qrad >> ALPHA_SH);
    assign req_ready_o = (r_q.st == ST_IDLE);
    assign hit_o       = (r_q.st == ST_RESP) && r_q.found;
    assign miss_o      = (r_q.st == ST_RESP) && !r_q.found;
    assign hit_idx_o   = r_q.best;
    assign hit_nbr_o   = r_q.enbr[r_q.best];
    assign hit_cnt_o   = r_q.ecnt[r_q.best];
    assign miss_pos_o  = r_q.qpos;
    assign miss_rad_o  = !radius_mode_i ? '1 : (grow[DIST_W] ? '1 : grow[DIST_W-1:0]);
endmodule

// File: rtl/cnc_ctrl_chk.sv
`timescale 1ns/1ps
module cnc_ctrl_chk #(
    parameter int N_ENTRY = 8,
    parameter int K_NBR   = 4,
    parameter int COORD_W = 10,
    parameter int DIST_W  = 12,
    localparam int CNT_W  = $clog2(K_NBR + 1),
    localparam int POS_W  = 3 * COORD_W,
    localparam int LAT_W  = $clog2(N_ENTRY) + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              radius_mode_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [POS_W-1:0]  req_pos_i,
    input logic [DIST_W-1:0] req_rad_i,
    input logic              hit_o,
    input logic [CNT_W-1:0]  hit_cnt_o,
    input logic              miss_o,
    input logic [POS_W-1:0]  miss_pos_o,
    input logic [DIST_W-1:0] miss_rad_o,
    input logic              fill_valid_i
);
    logic [LAT_W-1:0]  lat_q;
    logic [POS_W-1:0]  cap_pos_q;
    logic [DIST_W-1:0] cap_rad_q;
    logic              any_fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q      <= '1;
            cap_pos_q  <= '0;
            cap_rad_q  <= '0;
            any_fill_q <= 1'b0;
        end else begin
            if (fill_valid_i) any_fill_q <= 1'b1;
            if (req_valid_i && req_ready_o) begin
                lat_q     <= '0;
                cap_pos_q <= req_pos_i;
                cap_rad_q <= req_rad_i;
            end else if (lat_q != '1) begin
                lat_q <= lat_q + 1'b1;
            end
        end
    end

    p_one_kind_r2: assert property (@(posedge clk) disable iff (!rst_n) !(hit_o && miss_o));
    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o || miss_o) |-> (lat_q == LAT_W'(N_ENTRY)));
    p_cold_miss_r1: assert property (@(posedge clk) disable iff (!rst_n) !any_fill_q |-> !hit_o);
    p_miss_pos_r4: assert property (@(posedge clk) disable iff (!rst_n) miss_o |-> (miss_pos_o == cap_pos_q));
    p_unbounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_o && !radius_mode_i) |-> (miss_rad_o == '1));
    p_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_o && radius_mode_i) |-> (miss_rad_o >= cap_rad_q));
    p_knn_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !radius_mode_i) |-> (hit_cnt_o == CNT_W'(K_NBR)));
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (hit_cnt_o <= CNT_W'(K_NBR)));
endmodule

bind cnc_ctrl cnc_ctrl_chk #(
    .N_ENTRY (N_ENTRY),
    .K_NBR   (K_NBR),
    .COORD_W (COORD_W),
    .DIST_W  (DIST_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .radius_mode_i (radius_mode_i),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_pos_i     (req_pos_i),
    .req_rad_i     (req_rad_i),
    .hit_o         (hit_o),
    .hit_cnt_o     (hit_cnt_o),
    .miss_o        (miss_o),
    .miss_pos_o    (miss_pos_o),
    .miss_rad_o    (miss_rad_o),
    .fill_valid_i  (fill_valid_i)
);

// File: tb/sim_cnc_ctrl.sv
`timescale 1ns/1ps
module sim_cnc_ctrl;
    localparam int NE = 8, KN = 4, CW = 10, DW = 12, PW = 8;
    localparam int IW = $clog2(NE), CNW = $clog2(KN + 1), POSW = 3 * CW, NBW = KN * PW;

    logic clk = 1'b0, rst_n = 1'b0, radius_mode = 1'b0;
    logic req_valid = 1'b0, fill_valid = 1'b0;
    logic [POSW-1:0] req_pos = '0, fill_pos = '0;
    logic [DW-1:0]   req_rad = '0, fill_dk = '0, fill_dk1 = '0;
    logic [NBW-1:0]  fill_ptr = '0;
    logic [KN-1:0]   fill_empty = '0;
    logic req_ready, hit_o, miss_o;
    logic [IW-1:0]   hit_idx;
    logic [NBW-1:0]  hit_nbr;
    logic [CNW-1:0]  hit_cnt;
    logic [POSW-1:0] miss_pos;
    logic [DW-1:0]   miss_rad;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cnc_ctrl #(.N_ENTRY(NE), .K_NBR(KN), .COORD_W(CW), .DIST_W(DW), .PTR_W(PW), .ALPHA_SH(1)) u0 (
        .clk(clk), .rst_n(rst_n), .radius_mode_i(radius_mode),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_pos_i(req_pos), .req_rad_i(req_rad),
        .hit_o(hit_o), .hit_idx_o(hit_idx), .hit_nbr_o(hit_nbr), .hit_cnt_o(hit_cnt),
        .miss_o(miss_o), .miss_pos_o(miss_pos), .miss_rad_o(miss_rad),
        .fill_valid_i(fill_valid), .fill_pos_i(fill_pos), .fill_dk_i(fill_dk), .fill_dk1_i(fill_dk1),
        .fill_ptr_i(fill_ptr), .fill_empty_i(fill_empty)
    );

    typedef struct {
        bit              hit;
        int              idx;
        logic [NBW-1:0]  nbr;
        int              cnt;
        logic [POSW-1:0] pos;
        int              rad;
        int              acc;
        string           tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(string tag, longint act, longint expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [POSW-1:0] pos3(int x, int y, int z);
        return {CW'(z), CW'(y), CW'(x)};
    endfunction

    function automatic logic [NBW-1:0] nbr4(int b, bit [KN-1:0] zm);
        logic [NBW-1:0] v;
        for (int s = 0; s < KN; s++) v[s*PW +: PW] = zm[s] ? '0 : PW'(b + s);
        return v;
    endfunction

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(int x, int y, int z, int r, bit hit, int idx, int b, bit [KN-1:0] zm,
                          int cnt, int mrad, string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.hit = hit; e.idx = idx; e.nbr = nbr4(b, zm); e.cnt = cnt;
        e.pos = pos3(x, y, z); e.rad = mrad; e.acc = cyc; e.tag = tag;
        exp_q.push_back(e);
        req_pos = pos3(x, y, z); req_rad = DW'(r); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_empty();
    endtask

    task automatic req_hit(int x, int y, int z, int r, int idx, int b, bit [KN-1:0] zm, int cnt, string tag);
        do_req(x, y, z, r, 1'b1, idx, b, zm, cnt, 0, tag);
    endtask

    task automatic req_miss(int x, int y, int z, int r, int mrad, string tag);
        do_req(x, y, z, r, 1'b0, 0, 0, '0, 0, mrad, tag);
    endtask

    task automatic set_fill(int x, int y, int z, int dk, int dk1, int b, bit [KN-1:0] em);
        fill_pos = pos3(x, y, z); fill_dk = DW'(dk); fill_dk1 = DW'(dk1);
        fill_ptr = nbr4(b, '0); fill_empty = em;
    endtask

    task automatic do_fill(int x, int y, int z, int dk, int dk1, int b, bit [KN-1:0] em);
        @(negedge clk);
        set_fill(x, y, z, dk, dk1, b, em);
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on every response.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (hit_o || miss_o)) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected response", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk({e.tag, " R2 latency"}, cyc - e.acc, NE + 1);
                chk({e.tag, " R2 single kind"}, hit_o && miss_o, 0);
                chk({e.tag, " hit flag"}, hit_o, e.hit);
                if (e.hit) begin
                    chk({e.tag, " index"}, hit_idx, e.idx);
                    chk({e.tag, " pointers"}, longint'(hit_nbr), longint'(e.nbr));
                    chk({e.tag, " count"}, hit_cnt, e.cnt);
                end else begin
                    chk({e.tag, " miss position"}, longint'(miss_pos), longint'(e.pos));
                    chk({e.tag, " miss radius"}, miss_rad, e.rad);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 no hit after reset", hit_o, 0);
        chk("R1 no miss after reset", miss_o, 0);
        req_miss(0, 0, 0, 0, 4095, "R1 R4 cold miss");

        // R7 fills after reset land on entries 7,6,...; c = (60-40)/2 = 10
        for (int j = 0; j < NE; j++) do_fill(-400 + 100 * j, 0, 0, 40, 60, 16 * j, '0);

        // R3 strict tolerance test
        req_hit(-400 + 300 + 9, 0, 0, 0, 4, 48, '0, 4, "R3 inside tolerance");
        req_miss(100 + 6, 8, 0, 0, 4095, "R3 R4 on boundary");

        // R7 recency: touch oldest, then the next fill evicts the second oldest
        req_hit(-400 + 1, 0, 0, 0, 7, 0, '0, 4, "R7 touch oldest");
        do_fill(400, 0, 0, 40, 60, 128, '0);
        req_miss(-300, 0, 0, 0, 4095, "R7 evicted entry");
        req_hit(-400, 0, 0, 0, 7, 0, '0, 4, "R7 touched entry kept");
        req_hit(400, 0, 0, 0, 6, 128, '0, 4, "R7 refilled entry");

        // R8 two entries cover the query; the newer wins
        req_hit(-200, 0, 0, 0, 5, 32, '0, 4, "R8 touch older cover");
        do_fill(-195, 0, 0, 40, 80, 144, '0);
        req_hit(-198, 0, 0, 0, 3, 144, '0, 4, "R8 most recent of two hits");

        // R9 fill and request on the same edge; victim entry 2 held position 100
        begin
            exp_t e;
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            e.hit = 1'b0; e.idx = 0; e.nbr = '0; e.cnt = 0; e.pos = pos3(100, 0, 0);
            e.rad = 4095; e.acc = cyc; e.tag = "R9 refill hides victim";
            exp_q.push_back(e);
            req_pos = pos3(100, 0, 0); req_rad = '0; req_valid = 1'b1;
            set_fill(-500, 0, 0, 40, 60, 160, '0);
            fill_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0; fill_valid = 1'b0;
            wait_empty();
        end
        req_hit(-500, 0, 0, 0, 2, 160, '0, 4, "R9 new contents visible");

        // Radius mode, entered across a reset
        radius_mode = 1'b1;
        do_reset();
        req_miss(0, 0, 0, 100, 150, "R5 enlarged radius");
        req_miss(0, 0, 0, 4000, 4095, "R5 saturated radius");
        // R6 slots 3 empty; tolerance 150
        do_fill(0, 0, 0, 150, 150, 32, 4'b1000);
        req_miss(30, 40, 0, 100, 150, "R5 margin boundary");
        req_hit(30, 40, 0, 99, 7, 32, 4'b1000, 3, "R6 R5 radius hit discards empty");
        req_miss(0, 0, 0, 150, 225, "R5 zero margin");
        req_miss(0, 0, 0, 200, 300, "R5 negative margin");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule